// File: doc/BRIEF.md
# Dual-Source Interrupt Level and Vector Unit

This unit sits between two serial engines (a synchronous queued port and an asynchronous port) and the processor's interrupt logic. Each engine raises a pending flag; software assigns each engine a 3-bit priority level through a small register port. The unit chooses one winning source and pulls low the single request line that matches that source's level.

When the processor runs an acknowledge cycle, it presents the level it is servicing. The unit checks that level against the levels of the pending sources. If one matches, the unit returns an 8-bit vector one cycle later. The upper seven bits of the vector come from a shared register. The lowest bit is set by hardware and tells which source is being served. The acknowledge does not clear a pending flag. A request stays up until the engine drops its own flag.

Top module: `irqvec_unit`

## Requirements
- R1: After reset, both level fields read as 0, the vector register reads 0x0F, all seven request lines are high (inactive) and `vec_valid` is low.
- R2: A source whose level field is 0 never causes a request line to go low and never answers an acknowledge, even while its pending flag is set.
- R3: At most one request line is low at any time. When the winning level is L (1..7), line `irq_n[L-1]` is the low one. The lines reflect the levels and pending flags one clock after those change.
- R4: When both sources are active with different non-zero levels, the higher level wins, whichever source holds it.
- R5: When both sources are active with equal non-zero levels, the synchronous port wins. An acknowledge at that level returns a vector with bit 0 equal to 1.
- R6: A successful acknowledge raises `vec_valid` for one cycle, one clock after `iack` is sampled. Bits [7:1] of `vec_out` equal bits [7:1] of the vector register. Bit 0 of `vec_out` is 1 for the synchronous port and 0 for the asynchronous port.
- R7: Register addresses are 0 = synchronous level, 1 = asynchronous level, 2 = vector, 3 = reads zero. Level fields occupy data bits [2:0] and read back with the upper bits zero. A write to vector bit 0 is ignored, and reads of the vector return 1 in bit 0.
- R8: If the acknowledged level matches no active source's level, including an acknowledge at level 0, `vec_valid` stays low.
- R9: An acknowledge does not remove a request. The request line stays low until the source's pending flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pend_sync | input | 1 | Pending flag from the synchronous port |
| pend_async | input | 1 | Pending flag from the asynchronous port |
| irq_n | output | 7 | Active-low request lines, bit k for level k+1 |
| iack | input | 1 | Acknowledge cycle strobe |
| iack_level | input | 3 | Level being acknowledged |
| vec_valid | output | 1 | Vector response valid |
| vec_out | output | 8 | Vector number |

## Verification
The bench sweeps every pair of level values together with every combination of the two pending flags. This separates the disabled case, the single-source case, the case where the higher level wins, and the equal-level tie. For each pattern it acknowledges at all eight levels. Matching and non-matching levels show whether the unit answers, and bit 0 shows which source answered. The vector register is rewritten for each pattern with bit 0 alternating, which shows that bit 0 is forced on write and on read. The request lines are checked again after the acknowledges to confirm that they persist.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
    localparam int LVL_W     = 3;
    localparam int NUM_LINES = (1 << LVL_W) - 1;
    localparam int VEC_W     = 8;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam logic [VEC_W-1:0] VEC_RESET = 8'h0F;

    localparam logic [ADDR_W-1:0] A_LVL_SYNC  = 2'd0;
    localparam logic [ADDR_W-1:0] A_LVL_ASYNC = 2'd1;
    localparam logic [ADDR_W-1:0] A_VECTOR    = 2'd2;

    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [VEC_W-2:0]   vec_hi_t;
    typedef logic [NUM_LINES-1:0] lines_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SYNC  = 2'd1,
        SRC_ASYNC = 2'd2
    } src_t;

    typedef struct packed {
        src_t src;
        lvl_t level;
    } grant_t;

    function automatic lines_t level_to_lines(lvl_t l);
        lines_t m;
        m = '0;
        for (int i = 1; i <= NUM_LINES; i++) begin
            if (l == lvl_t'(i)) m[i-1] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irqvec_regs.sv
module irqvec_regs
    import irqvec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output lvl_t              lvl_sync,
    output lvl_t              lvl_async,
    output vec_hi_t           vec_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_sync  <= '0;
            lvl_async <= '0;
            vec_hi    <= VEC_RESET[VEC_W-1:1];
        end else if (wr) begin
            case (addr)
                A_LVL_SYNC:  lvl_sync  <= wdata[LVL_W-1:0];
                A_LVL_ASYNC: lvl_async <= wdata[LVL_W-1:0];
                A_VECTOR:    vec_hi    <= wdata[VEC_W-1:1];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_LVL_SYNC:  rdata[LVL_W-1:0] = lvl_sync;
            A_LVL_ASYNC: rdata[LVL_W-1:0] = lvl_async;
            A_VECTOR:    rdata[VEC_W-1:0] = {vec_hi, 1'b1};
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqvec_arb.sv
module irqvec_arb
    import irqvec_pkg::*;
(
    input  lvl_t   lvl_sync,
    input  lvl_t   lvl_async,
    input  logic   pend_sync,
    input  logic   pend_async,
    output grant_t grant
);
    logic act_s, act_a;

    always_comb begin
        act_s = pend_sync  && (lvl_sync  != '0);
        act_a = pend_async && (lvl_async != '0);
        if (act_s && (!act_a || lvl_sync >= lvl_async)) begin
            grant.src   = SRC_SYNC;
            grant.level = lvl_sync;
        end else if (act_a) begin
            grant.src   = SRC_ASYNC;
            grant.level = lvl_async;
        end else begin
            grant.src   = SRC_NONE;
            grant.level = '0;
        end
    end
endmodule

// File: rtl/irqvec_resp.sv
module irqvec_resp
    import irqvec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    iack,
    input  lvl_t    iack_level,
    input  lvl_t    lvl_sync,
    input  lvl_t    lvl_async,
    input  logic    pend_sync,
    input  logic    pend_async,
    input  vec_hi_t vec_hi,
    output logic    vec_valid,
    output vec_t    vec_out
);
    src_t hit;

    always_comb begin
        hit = SRC_NONE;
        if (pend_sync && lvl_sync != '0 && lvl_sync == iack_level)
            hit = SRC_SYNC;
        else if (pend_async && lvl_async != '0 && lvl_async == iack_level)
            hit = SRC_ASYNC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= iack && (hit != SRC_NONE);
            if (iack && hit != SRC_NONE)
                vec_out <= {vec_hi, (hit == SRC_SYNC)};
        end
    end
endmodule

// File: rtl/irqvec_unit.sv
module irqvec_unit
    import irqvec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pend_sync,
    input  logic              pend_async,
    output logic [NUM_LINES-1:0] irq_n,
    input  logic              iack,
    input  logic [LVL_W-1:0]  iack_level,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out
);
    lvl_t    lvl_sync, lvl_async;
    vec_hi_t vec_hi;
    grant_t  grant;
    lines_t  line_sel;

    irqvec_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .lvl_sync(lvl_sync), .lvl_async(lvl_async), .vec_hi(vec_hi)
    );

    irqvec_arb u_arb (
        .lvl_sync(lvl_sync), .lvl_async(lvl_async),
        .pend_sync(pend_sync), .pend_async(pend_async),
        .grant(grant)
    );

    irqvec_resp u_resp (
        .clk(clk), .rst(rst), .iack(iack), .iack_level(iack_level),
        .lvl_sync(lvl_sync), .lvl_async(lvl_async),
        .pend_sync(pend_sync), .pend_async(pend_async),
        .vec_hi(vec_hi), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    assign line_sel = level_to_lines(grant.level);

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) irq_n[k] <= 1'b1;
            else     irq_n[k] <= ~line_sel[k];
        end
    end
endmodule

// File: rtl/irqvec_chk.sv
module irqvec_chk
    import irqvec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NUM_LINES-1:0] irq_n,
    input logic              iack,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec_out,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input lvl_t              lvl_sync,
    input lvl_t              lvl_async,
    input vec_hi_t           vec_hi
);
    // R3: never more than one request line low
    p_one_line_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~irq_n));

    // R2: both levels zero means no request on the following cycle
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (lvl_sync == '0 && lvl_async == '0) |=> (&irq_n));

    // R8: a vector only follows an acknowledge
    p_resp_needs_ack_r8: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(iack));

    // R6: upper vector bits come from the register held at the acknowledge
    p_vec_upper_r6: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_out[VEC_W-1:1] == $past(vec_hi)));

    // R7: vector reads always show bit 0 set
    p_vec_lsb_read_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_VECTOR) |-> reg_rdata[0]);
endmodule

bind irqvec_unit irqvec_chk u_chk (
    .clk(clk), .rst(rst), .irq_n(irq_n), .iack(iack),
    .vec_valid(vec_valid), .vec_out(vec_out),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .lvl_sync(lvl_sync), .lvl_async(lvl_async), .vec_hi(vec_hi)
);

// File: tb/sim_irqvec_unit.sv
`timescale 1ns/1ps
module sim_irqvec_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       pend_sync = 1'b0, pend_async = 1'b0;
    logic [6:0] irq_n;
    logic       iack = 1'b0;
    logic [2:0] iack_level = 3'd0;
    logic       vec_valid;
    logic [7:0] vec_out;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irqvec_unit u0 (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    function automatic logic [6:0] exp_lines(int ls, int la, bit ps, bit pa);
        int w;
        bit as, aa;
        as = ps && ls != 0; aa = pa && la != 0;
        w = 0;
        if (as) w = ls;
        if (aa && la > w) w = la;
        if (w == 0) return 7'h7F;
        return ~(7'(1) << (w - 1));
    endfunction

    initial begin
        logic [7:0] d;
        logic [7:0] vw;
        logic [6:0] el;
        bit as, aa, ev;
        logic [7:0] evec;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        rd(2'd0, d); check("R1 sync level", d, 8'h00);
        rd(2'd1, d); check("R1 async level", d, 8'h00);
        rd(2'd2, d); check("R1 vector", d, 8'h0F);
        check("R1 lines", {1'b0, irq_n}, 8'h7F);
        check("R1 valid", {7'd0, vec_valid}, 8'h00);
        rd(2'd3, d); check("R7 unused addr", d, 8'h00);

        for (int ls = 0; ls < 8; ls++)
            for (int la = 0; la < 8; la++)
                for (int pp = 0; pp < 4; pp++) begin
                    bit ps, pa;
                    ps = pp[1]; pa = pp[0];
                    vw = {3'(ls), 3'(la), ps, pa};
                    wr(2'd0, {5'h1F, 3'(ls)});
                    wr(2'd1, {5'h15, 3'(la)});
                    wr(2'd2, vw);
                    rd(2'd0, d); check("R7 sync level readback", d, 8'(ls));
                    rd(2'd1, d); check("R7 async level readback", d, 8'(la));
                    rd(2'd2, d); check("R7 vector bit0 forced", d, vw | 8'h01);
                    pend_sync = ps; pend_async = pa;
                    @(posedge clk); @(negedge clk);
                    el = exp_lines(ls, la, ps, pa);
                    // R2 R3 R4 R5: line chosen by winning level
                    check("R3 R4 R2 R5 lines", {1'b0, irq_n}, {1'b0, el});
                    as = ps && ls != 0; aa = pa && la != 0;
                    for (int al = 0; al < 8; al++) begin
                        iack = 1'b1; iack_level = 3'(al);
                        @(posedge clk); @(negedge clk);
                        iack = 1'b0;
                        ev = 1'b0; evec = 8'h00;
                        if (as && ls == al) begin ev = 1'b1; evec = {vw[7:1], 1'b1}; end
                        else if (aa && la == al) begin ev = 1'b1; evec = {vw[7:1], 1'b0}; end
                        check("R8 R2 valid", {7'd0, vec_valid}, {7'd0, ev});
                        if (ev) check("R6 R5 vector", vec_out, evec);
                    end
                    @(negedge clk);
                    check("R9 lines held after ack", {1'b0, irq_n}, {1'b0, el});
                    pend_sync = 1'b0; pend_async = 1'b0;
                    @(posedge clk); @(negedge clk);
                    check("R9 lines drop on clear", {1'b0, irq_n}, 8'h7F);
                end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule